// File: doc/BRIEF.md
# Video Sync Timing Measurement Unit

This block measures the horizontal and vertical sync inputs of a display front end so that firmware can identify the incoming video mode. Both sync inputs first pass through a glitch filter and a rising-edge detector. A vertical period counter counts fixed-length ticks between successive vertical edges. A horizontal counter counts horizontal edges, either between two vertical edges or within a fixed window.

Each measurement is copied into a read-only result register at the end of its interval. The counter then restarts. Each counter owns a sticky overflow flag that reports a missing or too-slow sync. A clear strobe for a flag also zeroes the matching running counter. At the 8 MHz reference clock the defaults give an 8 µs tick (64 clocks) and an 8.192 ms window (65536 clocks). All three lengths are parameters.

Top module: `sync_meter`

## Requirements
- R1: An input high for only one sampled clock is ignored. An input that is high for two or more samples, after at least one low sample, yields exactly one rising edge. That edge takes effect on the third clock edge after the input first goes high.
- R2: On each vertical rising edge, `vert_period` loads the number of completed TICK_CLKS-clock ticks since the previous vertical edge. For edges P clocks apart this is floor((P-1)/TICK_CLKS). The counter then restarts from zero, and `vert_period` holds its value between vertical edges.
- R3: If the vertical counter is at its maximum (4095 for a 12-bit width) and another tick completes, `vert_ovf` sets and stays set. The counter saturates and does not wrap, so a later vertical edge loads 4095.
- R4: A high on `clr_vert_ovf` at a clock edge clears `vert_ovf` and zeroes the vertical counter and its tick divider. The clear wins over a simultaneous overflow. A vertical edge at the same clock edge still loads the old count into `vert_period`.
- R5: With `hwin_sel` = 1, `horz_count` loads, on each vertical edge, the number of horizontal edges from the previous vertical edge up to the clock before this one. A horizontal edge that coincides with a vertical edge counts toward the next interval.
- R6: With `hwin_sel` = 0, `horz_count` loads every WINDOW_CLKS clocks the number of horizontal edges in the window just ended. Any change of `hwin_sel` restarts the window and the horizontal counter at that clock edge.
- R7: A horizontal edge arriving while the horizontal counter is at its maximum sets `horz_ovf`. The flag stays set across later loads, and the counter saturates at the maximum.
- R8: A high on `clr_horz_ovf` clears `horz_ovf` and zeroes the horizontal counter. This clear wins over a simultaneous overflow or edge.
- R9: During and after reset, before any sync edge, both result registers read zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (8 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Raw horizontal sync, active high |
| vsync_in | input | 1 | Raw vertical sync, active high |
| hwin_sel | input | 1 | 1: count per vertical interval, 0: count per fixed window |
| clr_vert_ovf | input | 1 | Clear vertical flag and vertical counter |
| clr_horz_ovf | input | 1 | Clear horizontal flag and horizontal counter |
| vert_period | output | CNT_W | Latched vertical period in ticks |
| horz_count | output | CNT_W | Latched horizontal edge count |
| vert_ovf | output | 1 | Sticky vertical overflow |
| horz_ovf | output | 1 | Sticky horizontal overflow |

## Verification
A vertical edge and a clear strobe can act on the same clock edge. The bench provokes this after the vertical counter has saturated: it times the clear to the third edge after the vertical input rises. It then requires `vert_period` to show the saturated 4095 and `vert_ovf` to read low at that same edge. One period later it requires a normal count, which shows the tick divider restarted from zero. A horizontal edge can also coincide with an interval boundary, vertical or window. The period sweeps cover this, and the expected counts assign such an edge to the following interval.

// File: rtl/sync_meter_pkg.sv
package sync_meter_pkg;

  typedef enum logic {
    HWIN_FIXED = 1'b0,
    HWIN_VERT  = 1'b1
  } hwin_e;

  // Saturating increment: stays at top once reached.
  function automatic int unsigned sat_next(int unsigned cur, int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // True when a saturated counter would be pushed past its top.
  function automatic logic would_overflow(int unsigned cur, int unsigned top, logic step);
    return step && (cur >= top);
  endfunction

endpackage

// File: rtl/sm_glitch_filter.sv
module sm_glitch_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);
  logic smp_q;
  logic filt_q;
  logic filt_d;

  // The filtered level follows the input only after two equal samples.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      filt_q <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      smp_q  <= raw;
      if (raw == smp_q) filt_q <= smp_q;
      filt_d <= filt_q;
    end
  end

  assign rise = filt_q & ~filt_d;
endmodule

// File: rtl/sm_period_counter.sv
module sm_period_counter #(
  parameter int CNT_W     = 12,
  parameter int TICK_CLKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  input  logic             clr,
  output logic [CNT_W-1:0] result,
  output logic             ovf
);
  import sync_meter_pkg::*;

  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0]    PRE_LAST = PW'(TICK_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             restart;

  assign tick    = (pre_q == PRE_LAST);
  assign restart = clr | edge_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      if (restart || tick) pre_q <= '0;
      else                 pre_q <= pre_q + 1'b1;

      if (edge_in) result <= cnt_q;

      if (restart)   cnt_q <= '0;
      else if (tick) cnt_q <= CNT_W'(sat_next(32'(cnt_q), 32'(CNT_MAX)));

      if (clr) ovf <= 1'b0;
      else if (!edge_in && would_overflow(32'(cnt_q), 32'(CNT_MAX), tick)) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sm_window_timer.sv
module sm_window_timer #(
  parameter int WINDOW_CLKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic win_end,
  output logic sel_change
);
  localparam int TW = (WINDOW_CLKS > 1) ? $clog2(WINDOW_CLKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(WINDOW_CLKS - 1);

  logic [TW-1:0] tmr_q;
  logic          sel_q;

  assign sel_change = (sel != sel_q);
  assign win_end    = (tmr_q == T_LAST) && !sel_change;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (sel_change || win_end) tmr_q <= '0;
      else                       tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/sm_pulse_counter.sv
module sm_pulse_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic             latch,
  input  logic             restart,
  input  logic             clr,
  output logic [CNT_W-1:0] result,
  output logic             ovf
);
  import sync_meter_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             boundary;

  assign boundary = latch | restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      if (latch) result <= cnt_q;

      // A pulse on a boundary belongs to the interval that starts there.
      if (clr)           cnt_q <= '0;
      else if (boundary) cnt_q <= {{(CNT_W-1){1'b0}}, pulse};
      else if (pulse)    cnt_q <= CNT_W'(sat_next(32'(cnt_q), 32'(CNT_MAX)));

      if (clr) ovf <= 1'b0;
      else if (!boundary && would_overflow(32'(cnt_q), 32'(CNT_MAX), pulse)) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_meter.sv
module sync_meter #(
  parameter int CNT_W       = 12,
  parameter int TICK_CLKS   = 64,
  parameter int WINDOW_CLKS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             hwin_sel,
  input  logic             clr_vert_ovf,
  input  logic             clr_horz_ovf,
  output logic [CNT_W-1:0] vert_period,
  output logic [CNT_W-1:0] horz_count,
  output logic             vert_ovf,
  output logic             horz_ovf
);
  import sync_meter_pkg::*;

  // Named internal events, visible to the bound checker.
  logic v_rise;
  logic h_rise;
  logic win_end;
  logic sel_change;
  logic h_latch;

  sm_glitch_filter u_vflt (.clk(clk), .rst_n(rst_n), .raw(vsync_in), .rise(v_rise));
  sm_glitch_filter u_hflt (.clk(clk), .rst_n(rst_n), .raw(hsync_in), .rise(h_rise));

  sm_period_counter #(.CNT_W(CNT_W), .TICK_CLKS(TICK_CLKS)) u_vper (
    .clk(clk), .rst_n(rst_n), .edge_in(v_rise), .clr(clr_vert_ovf),
    .result(vert_period), .ovf(vert_ovf)
  );

  sm_window_timer #(.WINDOW_CLKS(WINDOW_CLKS)) u_win (
    .clk(clk), .rst_n(rst_n), .sel(hwin_sel), .win_end(win_end), .sel_change(sel_change)
  );

  assign h_latch = (hwin_e'(hwin_sel) == HWIN_VERT) ? v_rise : win_end;

  sm_pulse_counter #(.CNT_W(CNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .pulse(h_rise), .latch(h_latch),
    .restart(sel_change), .clr(clr_horz_ovf),
    .result(horz_count), .ovf(horz_ovf)
  );
endmodule

// File: rtl/sync_meter_chk.sv
module sync_meter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_vert_ovf,
  input logic             clr_horz_ovf,
  input logic             vert_ovf,
  input logic             horz_ovf,
  input logic [CNT_W-1:0] vert_period,
  input logic [CNT_W-1:0] horz_count,
  input logic             v_rise,
  input logic             h_rise,
  input logic             h_latch
);
  p_vrise_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_rise |=> !v_rise);
  p_hrise_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    h_rise |=> !h_rise);
  p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rise |=> $stable(vert_period));
  p_vsticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vert_ovf && !clr_vert_ovf) |=> vert_ovf);
  p_vclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vert_ovf |=> !vert_ovf);
  p_hhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !h_latch |=> $stable(horz_count));
  p_hsticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (horz_ovf && !clr_horz_ovf) |=> horz_ovf);
  p_hclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_horz_ovf |=> !horz_ovf);
endmodule

bind sync_meter sync_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .clr_vert_ovf(clr_vert_ovf), .clr_horz_ovf(clr_horz_ovf),
  .vert_ovf(vert_ovf), .horz_ovf(horz_ovf),
  .vert_period(vert_period), .horz_count(horz_count),
  .v_rise(v_rise), .h_rise(h_rise), .h_latch(h_latch)
);

// File: tb/sync_meter_test.sv
`timescale 1ns/1ps
module sync_meter_test;
  localparam int W    = 12;
  localparam int TK   = 4;
  localparam int WIN  = 64;
  localparam int MAXV = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, sel = 1'b1, clr_v = 1'b0, clr_h = 1'b0;
  logic [W-1:0] vper, hcnt;
  logic vov, hov;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sync_meter #(.CNT_W(W), .TICK_CLKS(TK), .WINDOW_CLKS(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .hwin_sel(sel),
    .clr_vert_ovf(clr_v), .clr_horz_ovf(clr_h),
    .vert_period(vper), .horz_count(hcnt), .vert_ovf(vov), .horz_ovf(hov)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    hs = 1'b0; vs = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Vertical-interval mode sweep; checks R2 and R5 (R1 when glitchy).
  task automatic run_vert(input int vp, input int hp, input bit glitch);
    for (int t = 0; t <= 4 * vp + 3; t++) begin
      @(negedge clk);
      if (t >= 2 * vp + 3 && (t - 3) % vp == 0) begin
        int m = (t - 3) / vp;
        int eh = 0;
        for (int j = 0; j * hp < m * vp; j++)
          if (j * hp >= (m - 1) * vp) eh++;
        chk(glitch ? "R1 vert" : "R2", int'(vper), (vp - 1) / TK);
        chk(glitch ? "R1 horz" : "R5", int'(hcnt), eh);
      end
      vs = ((t % vp) < 3) || (glitch && (t % vp) == vp / 2);
      hs = ((t % hp) < 2) || (glitch && (t % hp) == hp / 2 + 1);
    end
    idle(10);
  endtask

  // Fixed-window mode; selecting it restarts the window (R6).
  task automatic run_win(input int hp);
    for (int t = 0; t <= 3 * WIN + 1; t++) begin
      @(negedge clk);
      if (t >= 1 + WIN && (t - 1) % WIN == 0) begin
        int k = (t - 1) / WIN;
        int eh = 0;
        for (int j = 0; j * hp + 3 < 1 + k * WIN; j++)
          if (j * hp + 3 >= 1 + (k - 1) * WIN) eh++;
        chk("R6", int'(hcnt), eh);
      end
      sel = 1'b0;
      hs = (t % hp) < 2;
    end
    hs = 1'b0;
    sel = 1'b1;
    idle(10);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R9 vper in reset", int'(vper), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 vper", int'(vper), 0);
    chk("R9 hcnt", int'(hcnt), 0);
    chk("R9 vov", int'(vov), 0);
    chk("R9 hov", int'(hov), 0);

    for (int vp = 20; vp <= 55; vp += 7)
      for (int hp = 4; hp <= 9; hp++)
        run_vert(vp, hp, 1'b0);
    run_vert(20, 8, 1'b1);
    run_vert(41, 9, 1'b1);
    for (int hp = 4; hp <= 12; hp++)
      run_win(hp);

    // Vertical overflow and saturation, R3.
    clr_v = 1'b1; @(negedge clk); clr_v = 1'b0;
    idle(TK * (MAXV + 1) + 40);
    chk("R3 flag", int'(vov), 1);
    // Clear on the same edge as a vertical edge, R4.
    vs = 1'b1; @(negedge clk); @(negedge clk);
    clr_v = 1'b1; @(negedge clk);
    clr_v = 1'b0; vs = 1'b0;
    chk("R3 saturated load", int'(vper), MAXV);
    chk("R4 coincident clear", int'(vov), 0);
    repeat (47) @(negedge clk);
    vs = 1'b1; repeat (3) @(negedge clk); vs = 1'b0;
    chk("R4 restart after coincident clear", int'(vper), 49 / TK);

    // Clear alone, R4.
    idle(TK * (MAXV + 1) + 40);
    chk("R3 flag again", int'(vov), 1);
    clr_v = 1'b1; @(negedge clk); clr_v = 1'b0;
    chk("R4 clear alone", int'(vov), 0);
    repeat (37) @(negedge clk);
    vs = 1'b1; repeat (3) @(negedge clk); vs = 1'b0;
    chk("R4 counter zeroed", int'(vper), 39 / TK);

    // Horizontal overflow, R7 and R8.
    idle(10);
    for (int t = 0; t < 4 * (MAXV + 10); t++) begin
      hs = (t % 4) < 2;
      @(negedge clk);
    end
    idle(10);
    chk("R7 flag", int'(hov), 1);
    vs = 1'b1; repeat (3) @(negedge clk); vs = 1'b0;
    chk("R7 saturated load", int'(hcnt), MAXV);
    chk("R7 sticky across load", int'(hov), 1);
    idle(5);
    clr_h = 1'b1; @(negedge clk); clr_h = 1'b0;
    chk("R8 clear", int'(hov), 0);
    for (int t = 0; t < 20; t++) begin
      hs = (t % 4) < 2;
      @(negedge clk);
    end
    idle(5);
    vs = 1'b1; repeat (3) @(negedge clk); vs = 1'b0;
    chk("R8 counter zeroed", int'(hcnt), 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule